// File: doc/BRIEF.md
# Stream-to-OCP Burst Master Adapter

This block sits between a processor's outbound FIFO-style word stream and the request side of an on-chip interconnect that speaks an OCP-style master protocol. The processor pushes a command word and then an address word. For a write it then pushes one 64-bit data word per beat. The adapter turns these words into a request phase (command, address, burst length, pressure flag) and a write-data phase (valid, last marker). For reads it passes the slave's response beats back to the processor on a second valid/ready stream and marks the final beat.

The adapter handles one transaction at a time. A burst counter is loaded from the length field when the slave accepts the request. The counter places the data-last marker on write bursts, and on read bursts it is compared with the slave's last marker so that a mismatch raises an error pulse. An exclusive read locks the adapter against further reads until a write or a non-posted write has been issued, which completes the read-modify-write sequence.

Top module: `ocp_stream_master`

## Requirements
- R1: After reset, no request is driven (`m_cmd` = 0), `m_data_valid`, `rsp_valid` and `burst_err` are low, and `cmd_ready` is high.
- R2: A command word carries the opcode in bits 2:0 (1 write, 2 read, 3 exclusive read, 5 non-posted write), the burst length in bits 15:8 and the pressure level in bits 17:16. The next stream word supplies the address. The request then shows the opcode on `m_cmd`, the address on `m_addr`, the length on `m_blen` and the pressure on `m_flag`.
- R3: A request stays on `m_cmd`/`m_addr` without change until `s_cmd_acc` is high at a clock edge. While the request is pending, no stream word is taken (`cmd_ready` low).
- R4: After a write request is accepted, each stream word appears on `m_data` with `m_data_valid`. The word is taken from the stream only in a cycle where `s_data_acc` is high, so a stalled beat is never lost.
- R5: `m_data_last` is high on the beat whose number equals the burst length and low on every earlier beat.
- R6: During a read, a slave beat with a non-null response code (0 null, 1 data valid) drives `rsp_valid` and passes `s_data` and `s_resp` through. `m_resp_acc` follows `rsp_ready`. `rsp_last` is high on the beat whose number equals the burst length.
- R7: A non-posted write expects exactly one response beat after its data. A plain write expects none, and the adapter returns to accepting commands.
- R8: `burst_err` pulses high for one cycle after an accepted response beat whose `s_resp_last` differs from the counter's last-beat state. It stays low otherwise.
- R9: After an exclusive read has been issued, read and exclusive-read command words are dropped until a write or non-posted write request has been accepted.
- R10: A command word with an unknown opcode or a zero length is consumed and dropped. The next word is decoded as a command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Processor stream word valid |
| cmd_ready | output | 1 | Processor stream word taken |
| cmd_data | input | 64 | Processor stream word |
| rsp_valid | output | 1 | Response stream beat valid |
| rsp_ready | input | 1 | Processor accepts response beat |
| rsp_data | output | 64 | Response read data |
| rsp_code | output | 2 | Response code of the beat |
| rsp_last | output | 1 | Final beat of the burst |
| m_cmd | output | 3 | Request opcode, 0 when idle |
| m_addr | output | 32 | Request address |
| m_blen | output | 8 | Request burst length |
| m_flag | output | 2 | Request pressure level |
| s_cmd_acc | input | 1 | Slave accepts request |
| m_data | output | 64 | Write data beat |
| m_data_valid | output | 1 | Write data valid |
| m_data_last | output | 1 | Final write data beat |
| s_data_acc | input | 1 | Slave accepts write data |
| s_resp | input | 2 | Slave response code |
| s_data | input | 64 | Slave read data |
| s_resp_last | input | 1 | Slave marks final response beat |
| m_resp_acc | output | 1 | Master accepts response |
| burst_err | output | 1 | Last-marker mismatch pulse |

## Verification
The embedded assertions check four properties on every cycle: a pending request holds steady until it is accepted, the stream is blocked while a request is pending, the request, data and response phases never overlap, and no read is issued while the exclusive lock is held. The error pulse is also checked so that it only ever follows an accepted response beat. The bench scenarios are the only place where several behaviours can be shown: correct field extraction, beat data and the position of the last markers for several burst lengths, beats that are held through a stall, the single response of a non-posted write, dropped command words and the lock sequence.

// File: rtl/ocp_stream_master.sv
module ocp_stream_master #(
  parameter int DW = 64,
  parameter int AW = 32,
  parameter int LW = 8,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [DW-1:0] cmd_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic [1:0]    rsp_code,
  output logic          rsp_last,
  output logic [2:0]    m_cmd,
  output logic [AW-1:0] m_addr,
  output logic [LW-1:0] m_blen,
  output logic [PW-1:0] m_flag,
  input  logic          s_cmd_acc,
  output logic [DW-1:0] m_data,
  output logic          m_data_valid,
  output logic          m_data_last,
  input  logic          s_data_acc,
  input  logic [1:0]    s_resp,
  input  logic [DW-1:0] s_data,
  input  logic          s_resp_last,
  output logic          m_resp_acc,
  output logic          burst_err
);
  localparam logic [2:0] OP_IDLE = 3'd0, OP_WR = 3'd1, OP_RD = 3'd2,
                         OP_RDEX = 3'd3, OP_WRNP = 3'd5;
  localparam int LEN_LO  = 8;
  localparam int FLAG_LO = LEN_LO + LW;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_REQ, S_WDAT, S_RESP} state_t;
  state_t st;

  logic [2:0]    op_q;
  logic [LW-1:0] len_q, cnt;
  logic [PW-1:0] flag_q;
  logic [AW-1:0] addr_q;
  logic          locked, err_q;

  wire [2:0]    in_op   = cmd_data[2:0];
  wire [LW-1:0] in_len  = cmd_data[LEN_LO +: LW];
  wire          is_rd   = (in_op == OP_RD) || (in_op == OP_RDEX);
  wire          is_wr   = (in_op == OP_WR) || (in_op == OP_WRNP);
  wire          legal   = (in_len != '0) && (is_wr || (is_rd && !locked));
  wire          op_wr_q = (op_q == OP_WR) || (op_q == OP_WRNP);
  wire          on_last = (cnt == LW'(1));

  assign cmd_ready    = (st == S_IDLE) || (st == S_ADDR) || (st == S_WDAT && s_data_acc);
  assign m_cmd        = (st == S_REQ) ? op_q : OP_IDLE;
  assign m_addr       = addr_q;
  assign m_blen       = len_q;
  assign m_flag       = flag_q;
  assign m_data       = cmd_data;
  assign m_data_valid = (st == S_WDAT) && cmd_valid;
  assign m_data_last  = m_data_valid && on_last;
  assign rsp_valid    = (st == S_RESP) && (s_resp != 2'd0);
  assign rsp_data     = s_data;
  assign rsp_code     = s_resp;
  assign rsp_last     = on_last;
  assign m_resp_acc   = (st == S_RESP) && rsp_ready;
  assign burst_err    = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_IDLE;
      len_q  <= '0;
      cnt    <= '0;
      flag_q <= '0;
      addr_q <= '0;
      locked <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid && legal) begin
          op_q   <= in_op;
          len_q  <= in_len;
          flag_q <= cmd_data[FLAG_LO +: PW];
          st     <= S_ADDR;
        end
        S_ADDR: if (cmd_valid) begin
          addr_q <= cmd_data[AW-1:0];
          st     <= S_REQ;
        end
        S_REQ: if (s_cmd_acc) begin
          cnt <= len_q;
          st  <= op_wr_q ? S_WDAT : S_RESP;
          if (op_q == OP_RDEX) locked <= 1'b1;
          if (op_wr_q)         locked <= 1'b0;
        end
        S_WDAT: if (cmd_valid && s_data_acc) begin
          cnt <= cnt - LW'(1);
          if (on_last) begin
            if (op_q == OP_WRNP) begin
              cnt <= LW'(1);
              st  <= S_RESP;
            end else st <= S_IDLE;
          end
        end
        S_RESP: if (rsp_valid && rsp_ready) begin
          cnt   <= cnt - LW'(1);
          err_q <= (s_resp_last != on_last);
          if (on_last) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cmd != OP_IDLE && !s_cmd_acc) |=> (m_cmd == $past(m_cmd) && $stable(m_addr))); // R3
  AST_STREAM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cmd != OP_IDLE) |-> !cmd_ready); // R3
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_cmd != OP_IDLE && (m_data_valid || rsp_valid))); // R6
  AST_NO_READ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cmd == OP_RD || m_cmd == OP_RDEX) |-> !locked); // R9
  AST_ERR_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_err) |-> $past(m_resp_acc && s_resp != 2'd0)); // R8
endmodule

// File: tb/test_ocp_stream_master.sv
module test_ocp_stream_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_valid = 0, cmd_ready, rsp_valid, rsp_ready = 0, rsp_last;
  logic [63:0] cmd_data = 0, rsp_data, m_data, s_data = 0;
  logic [1:0]  rsp_code, m_flag, s_resp = 0;
  logic [2:0]  m_cmd;
  logic [31:0] m_addr;
  logic [7:0]  m_blen;
  logic        s_cmd_acc = 0, m_data_valid, m_data_last, s_data_acc = 0;
  logic        s_resp_last = 0, m_resp_acc, burst_err;

  ocp_stream_master i_ocp_stream_master (.*);

  int checks = 0, fails = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(logic [63:0] w);
    @(negedge clk); cmd_valid = 1; cmd_data = w;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1 cmd_valid = 0;
  endtask

  function automatic logic [63:0] cw(logic [2:0] op, logic [7:0] len, logic [1:0] fl);
    return 64'({fl, len, 5'b0, op});
  endfunction

  task automatic take_req(logic [2:0] op, logic [7:0] len, logic [1:0] fl, logic [31:0] a);
    @(negedge clk);
    check("R2 m_cmd", 64'(m_cmd), 64'(op));
    check("R2 m_addr", 64'(m_addr), 64'(a));
    check("R2 m_blen", 64'(m_blen), 64'(len));
    check("R2 m_flag", 64'(m_flag), 64'(fl));
    check("R3 stream blocked", 64'(cmd_ready), 64'(0));
    @(negedge clk);
    check("R3 held", 64'(m_cmd), 64'(op));
    s_cmd_acc = 1;
    @(posedge clk); #1 s_cmd_acc = 0;
  endtask

  task automatic wbeat(logic [63:0] d, logic last);
    @(negedge clk); cmd_valid = 1; cmd_data = d; s_data_acc = 0; #1;
    check("R4 data valid", 64'(m_data_valid), 64'(1));
    check("R4 data", m_data, d);
    check("R5 data last", 64'(m_data_last), 64'(last));
    check("R4 stall keeps word", 64'(cmd_ready), 64'(0));
    @(negedge clk); s_data_acc = 1; #1;
    check("R4 word taken", 64'(cmd_ready), 64'(1));
    @(posedge clk); #1 cmd_valid = 0; s_data_acc = 0;
  endtask

  task automatic rbeat(logic [63:0] d, logic lin, logic lexp);
    @(negedge clk); s_resp = 2'd1; s_data = d; s_resp_last = lin; rsp_ready = 0; #1;
    check("R6 rsp valid", 64'(rsp_valid), 64'(1));
    check("R6 rsp data", rsp_data, d);
    check("R6 rsp code", 64'(rsp_code), 64'(1));
    check("R6 rsp last", 64'(rsp_last), 64'(lexp));
    check("R6 acc follows ready", 64'(m_resp_acc), 64'(0));
    @(negedge clk); rsp_ready = 1; #1;
    check("R6 acc", 64'(m_resp_acc), 64'(1));
    @(posedge clk); #1 s_resp = 0; rsp_ready = 0; s_resp_last = 0;
    check("R8 burst_err", 64'(burst_err), 64'(lin != lexp));
  endtask

  task automatic run(logic [2:0] op, logic [7:0] len, logic [1:0] fl, logic [31:0] a, logic [7:0] eb);
    push(cw(op, len, fl));
    push(64'(a));
    take_req(op, len, fl, a);
    if (op == 3'd1 || op == 3'd5) begin
      for (int b = 0; b < int'(len); b++)
        wbeat({32'h5A5A0000 + 32'(b), a}, b == int'(len) - 1);
      if (op == 3'd5) rbeat(64'hC0DE_0000 ^ 64'(a), 1'b1, 1'b1);
      else begin
        @(negedge clk);
        check("R7 no response after write", 64'(rsp_valid), 64'(0));
        check("R7 back to idle", 64'(cmd_ready), 64'(1));
      end
    end else begin
      for (int b = 0; b < int'(len); b++)
        rbeat({a, 32'(b) * 32'h1111}, (b == int'(len) - 1) ^ (b == int'(eb)), b == int'(len) - 1);
    end
  endtask

  localparam int NV = 7;
  localparam logic [52:0] VEC [NV] = '{
    {3'd1, 8'd1, 2'd0, 32'h0000_1000, 8'hFF},
    {3'd1, 8'd4, 2'd3, 32'h0000_2040, 8'hFF},
    {3'd2, 8'd1, 2'd1, 32'h8000_0008, 8'hFF},
    {3'd2, 8'd3, 2'd2, 32'h1234_5670, 8'hFF},
    {3'd3, 8'd2, 2'd3, 32'h0000_4000, 8'hFF},
    {3'd5, 8'd1, 2'd3, 32'h0000_4000, 8'hFF},
    {3'd2, 8'd2, 2'd0, 32'hABCD_0000, 8'd0}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 m_cmd idle", 64'(m_cmd), 64'(0));
    check("R1 data valid low", 64'(m_data_valid), 64'(0));
    check("R1 rsp valid low", 64'(rsp_valid), 64'(0));
    check("R1 err low", 64'(burst_err), 64'(0));
    rst_n = 1;
    @(negedge clk);
    check("R1 ready", 64'(cmd_ready), 64'(1));

    for (int i = 0; i < NV; i++)
      run(VEC[i][52:50], VEC[i][49:42], VEC[i][41:40], VEC[i][39:8], VEC[i][7:0]);

    // R10: unknown opcode and zero length are dropped; next word is a command
    push(cw(3'd4, 8'd2, 2'd1));
    push(cw(3'd2, 8'd0, 2'd1));
    @(negedge clk);
    check("R10 dropped no request", 64'(m_cmd), 64'(0));
    run(3'd2, 8'd1, 2'd2, 32'h0000_0777, 8'hFF);

    // R9: read blocked while exclusive lock held, write releases it
    run(3'd3, 8'd1, 2'd0, 32'h0000_9000, 8'hFF);
    push(cw(3'd2, 8'd1, 2'd0));
    push(cw(3'd3, 8'd1, 2'd0));
    @(negedge clk);
    check("R9 locked read dropped", 64'(m_cmd), 64'(0));
    run(3'd1, 8'd2, 2'd0, 32'h0000_9000, 8'hFF);
    run(3'd2, 8'd1, 2'd1, 32'h0000_9008, 8'hFF);

    // R8: last marker absent on final beat
    run(3'd2, 8'd3, 2'd0, 32'h0000_A000, 8'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule